// File: doc/BRIEF.md
# SPI Register-Write Slave with Ready Handshake

This block receives register writes from an external SPI master and turns each one into a single parallel write command on the system-clock side. A write is framed by an active-low chip select; while that select is low the master shifts in one address byte and then one to seven data bytes, most significant bit first. When the select rises, the block checks that the byte count matches the length expected for that address. If it does, the block issues a one-cycle strobe with the address, the data bytes and the data-byte count. If it does not, the frame is dropped.

After a write is accepted, the ready output goes low for a programmable number of system-clock cycles to model command processing. A frame whose chip select falls while ready is low is ignored in full. The sampling edge of the serial clock is chosen by a mode pin. That pin is captured only while reset is asserted: low selects sampling on the rising edge and high selects sampling on the falling edge. All SPI inputs are brought into the system clock through two-flop synchronisers, so the system clock must run at least eight times faster than the serial clock.

Top module: `spi_reg_write_slave`

## Requirements
- R1: Bits are taken only while chip select is low, MSB first. The first byte becomes `wr_addr_o`, and data byte k (k = 0..6) appears on `wr_data_o[8k+7:8k]`. Data bytes that the frame does not carry read as zero.
- R2: The expected total frame length, address byte included, is 2 + addr[2:0] when addr[2:0] is 0 to 6, and 8 when addr[2:0] is 7. `wr_nbytes_o` gives the number of data bytes, which is the total minus one.
- R3: A frame is discarded with no strobe, and ready stays high, if any of the following holds: its byte count differs from the expected length, it ends part-way through a byte, or it carries more than 8 bytes.
- R4: An accepted frame gives exactly one cycle of `wr_stb_o`. `ready_o` is low from that same cycle for BUSY_CYCLES cycles and then returns high. The command outputs hold their values until the next strobe.
- R5: A frame whose chip select falls while `ready_o` is low is ignored in full, even if ready returns high before the frame ends.
- R6: The mode pin is captured during reset. If it is low, bits are sampled on the rising edge of the serial clock. If it is high, bits are sampled on the falling edge.
- R7: Changes on the mode pin while reset is deasserted have no effect on the sampling edge.
- R8: `miso_oe_o` is high exactly while chip select is low, and `miso_o` drives 0.
- R9: After reset, `ready_o` is 1, `wr_stb_o` is 0, and the address, data and count outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; mode pin sampled while high |
| mode_pin_i | input | 1 | Edge select: 0 rising, 1 falling |
| sclk_i | input | 1 | Serial clock from master |
| mosi_i | input | 1 | Serial data from master |
| csn_i | input | 1 | Active-low chip select |
| miso_o | output | 1 | Serial data to master (driven 0) |
| miso_oe_o | output | 1 | Output enable for the MISO pad |
| wr_addr_o | output | 8 | Register address of last accepted write |
| wr_data_o | output | 56 | Data bytes of last accepted write |
| wr_nbytes_o | output | 4 | Data-byte count of last accepted write |
| wr_stb_o | output | 1 | One-cycle write strobe |
| ready_o | output | 1 | High when a new write can be taken |

## Verification
The assertions check on every cycle that the strobe lasts a single cycle and always coincides with ready falling. They also check that a strobe only follows a cycle in which ready was high, that the reported count agrees with the length rule for the reported address, that bytes complete only inside an armed frame, and that the latched mode does not change outside reset. Some behaviour can only be shown by the bench's scenarios: that the bytes are assembled in the right order and at the right edge, that malformed or overlapping frames are really dropped, that a mode pin toggled after reset is ignored, and that traffic clocked on the wrong edge is read as inverted data and rejected.

// File: rtl/spi_wr_pkg.sv
package spi_wr_pkg;

    localparam int BYTE_W     = 8;
    localparam int MAX_BYTES  = 8;
    localparam int DATA_BYTES = MAX_BYTES - 1;
    localparam int DATA_W     = DATA_BYTES * BYTE_W;
    localparam int CNT_W      = $clog2(MAX_BYTES + 1);
    localparam int IDX_W      = $clog2(MAX_BYTES);
    localparam int BIT_W      = $clog2(BYTE_W);

    typedef enum logic {
        MODE_RISE = 1'b0,
        MODE_FALL = 1'b1
    } spi_mode_e;

    typedef struct packed {
        logic [BYTE_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [CNT_W-1:0]  nbytes;
    } wr_cmd_t;

    // total frame bytes (address included) expected for an address
    function automatic logic [CNT_W-1:0] frame_len(input logic [BYTE_W-1:0] a);
        if (a[2:0] == 3'd7)
            return CNT_W'(MAX_BYTES);
        return CNT_W'(a[2:0]) + CNT_W'(2);
    endfunction

endpackage

// File: rtl/spi_wr_sync.sv
module spi_wr_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0][STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst)
                    chain[i] <= {STAGES{RST_VAL[i]}};
                else
                    chain[i] <= {chain[i][STAGES-2:0], d_i[i]};
            end
            assign q_o[i] = chain[i][STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/spi_wr_shift.sv
module spi_wr_shift
    import spi_wr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  spi_mode_e         mode_i,
    input  logic              sclk_i,
    input  logic              mosi_i,
    input  logic              active_i,
    output logic              byte_vld_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              partial_o
);

    logic              sclk_d;
    logic [BIT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              samp_edge;
    logic [BYTE_W-1:0] shreg_nxt;

    always_comb begin
        if (mode_i == MODE_RISE)
            samp_edge = sclk_i & ~sclk_d;
        else
            samp_edge = ~sclk_i & sclk_d;
        shreg_nxt = {shreg[BYTE_W-2:0], mosi_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d     <= 1'b0;
            bit_cnt    <= '0;
            shreg      <= '0;
            byte_vld_o <= 1'b0;
            byte_o     <= '0;
        end else begin
            sclk_d     <= sclk_i;
            byte_vld_o <= 1'b0;
            if (!active_i) begin
                bit_cnt <= '0;
            end else if (samp_edge) begin
                shreg   <= shreg_nxt;
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == BIT_W'(BYTE_W - 1)) begin
                    byte_vld_o <= 1'b1;
                    byte_o     <= shreg_nxt;
                end
            end
        end
    end

    assign partial_o = (bit_cnt != '0);

    // R1
    byte_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        byte_vld_o |-> $past(active_i));

endmodule

// File: rtl/spi_wr_frame.sv
module spi_wr_frame
    import spi_wr_pkg::*;
#(
    parameter int BUSY_CYCLES = 250
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csn_i,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              partial_i,
    output logic              active_o,
    output wr_cmd_t           cmd_o,
    output logic              stb_o,
    output logic              ready_o
);

    localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

    logic              csn_d;
    logic              armed;
    logic [CNT_W-1:0]  cnt;
    logic              ovf;
    logic [BYTE_W-1:0] buf_q [MAX_BYTES];
    logic [BUSY_W-1:0] busy;
    logic              cs_fall, cs_rise, frame_ok;
    logic [DATA_W-1:0] data_nxt;

    assign cs_fall  = csn_d & ~csn_i;
    assign cs_rise  = ~csn_d & csn_i;
    assign ready_o  = (busy == '0);
    assign active_o = armed & ~csn_i;
    assign frame_ok = armed & cs_rise & ~partial_i & ~ovf & (cnt == frame_len(buf_q[0]));

    always_comb begin
        for (int k = 0; k < DATA_BYTES; k++)
            data_nxt[k*BYTE_W +: BYTE_W] = buf_q[k+1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            csn_d <= 1'b1;
            armed <= 1'b0;
            cnt   <= '0;
            ovf   <= 1'b0;
            busy  <= '0;
            stb_o <= 1'b0;
            cmd_o <= '0;
            for (int k = 0; k < MAX_BYTES; k++) buf_q[k] <= '0;
        end else begin
            csn_d <= csn_i;
            stb_o <= 1'b0;
            if (busy != '0) busy <= busy - 1'b1;
            if (cs_fall) begin
                armed <= ready_o;
                cnt   <= '0;
                ovf   <= 1'b0;
                for (int k = 0; k < MAX_BYTES; k++) buf_q[k] <= '0;
            end else if (cs_rise) begin
                armed <= 1'b0;
                if (frame_ok) begin
                    cmd_o.addr   <= buf_q[0];
                    cmd_o.data   <= data_nxt;
                    cmd_o.nbytes <= cnt - 1'b1;
                    stb_o        <= 1'b1;
                    busy         <= BUSY_W'(BUSY_CYCLES);
                end
            end else if (armed && byte_vld_i) begin
                if (cnt == CNT_W'(MAX_BYTES))
                    ovf <= 1'b1;
                else begin
                    buf_q[cnt[IDX_W-1:0]] <= byte_i;
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R4
    stb_single_chk: assert property (@(posedge clk) disable iff (rst)
        stb_o |=> !stb_o);
    // R4
    stb_busy_chk: assert property (@(posedge clk) disable iff (rst)
        stb_o |-> !ready_o);
    // R5
    stb_after_ready_chk: assert property (@(posedge clk) disable iff (rst)
        stb_o |-> $past(ready_o));
    // R3
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ready_o) |-> stb_o);
    // R2
    stb_len_chk: assert property (@(posedge clk) disable iff (rst)
        stb_o |-> (cmd_o.nbytes + 1'b1 == frame_len(cmd_o.addr)));

endmodule

// File: rtl/spi_reg_write_slave.sv
module spi_reg_write_slave
    import spi_wr_pkg::*;
#(
    parameter int BUSY_CYCLES = 250,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_pin_i,
    input  logic              sclk_i,
    input  logic              mosi_i,
    input  logic              csn_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    output logic [BYTE_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [CNT_W-1:0]  wr_nbytes_o,
    output logic              wr_stb_o,
    output logic              ready_o
);

    spi_mode_e         mode_q;
    logic [2:0]        sync_q;
    logic              sclk_s, mosi_s, csn_s;
    logic              active, byte_vld, partial;
    logic [BYTE_W-1:0] byte_val;
    wr_cmd_t           cmd;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= spi_mode_e'(mode_pin_i);
    end

    spi_wr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({csn_i, mosi_i, sclk_i}),
        .q_o (sync_q)
    );
    assign {csn_s, mosi_s, sclk_s} = sync_q;

    spi_wr_shift u_shift (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode_q),
        .sclk_i     (sclk_s),
        .mosi_i     (mosi_s),
        .active_i   (active),
        .byte_vld_o (byte_vld),
        .byte_o     (byte_val),
        .partial_o  (partial)
    );

    spi_wr_frame #(.BUSY_CYCLES(BUSY_CYCLES)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .csn_i      (csn_s),
        .byte_vld_i (byte_vld),
        .byte_i     (byte_val),
        .partial_i  (partial),
        .active_o   (active),
        .cmd_o      (cmd),
        .stb_o      (wr_stb_o),
        .ready_o    (ready_o)
    );

    assign wr_addr_o   = cmd.addr;
    assign wr_data_o   = cmd.data;
    assign wr_nbytes_o = cmd.nbytes;
    assign miso_oe_o   = ~csn_i;
    assign miso_o      = 1'b0;

    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(mode_q));

endmodule

// File: tb/spi_reg_write_slave_bench.sv
`timescale 1ns/1ps
module spi_reg_write_slave_bench;
    import spi_wr_pkg::*;

    localparam int BUSY = 60;
    localparam int H    = 4;

    logic clk = 1'b0, rst = 1'b1, mode_pin = 1'b1;
    logic sclk = 1'b0, mosi = 1'b0, csn = 1'b1;
    logic miso, miso_oe, wr_stb, ready;
    logic [7:0]  wr_addr;
    logic [55:0] wr_data;
    logic [3:0]  wr_nbytes;

    spi_reg_write_slave #(.BUSY_CYCLES(BUSY)) u_spi_reg_write_slave (
        .clk(clk), .rst(rst), .mode_pin_i(mode_pin), .sclk_i(sclk), .mosi_i(mosi),
        .csn_i(csn), .miso_o(miso), .miso_oe_o(miso_oe), .wr_addr_o(wr_addr),
        .wr_data_o(wr_data), .wr_nbytes_o(wr_nbytes), .wr_stb_o(wr_stb), .ready_o(ready)
    );

    always #10 clk = ~clk;

    int checks = 0, fails = 0, model_busy = 0;
    bit dut_fall = 1'b1, done = 1'b0;
    logic [7:0]  q_addr[$];
    logic [55:0] q_data[$];
    int          q_len[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-cycle reference model
    always begin
        @(posedge clk); #1;
        if (rst) model_busy = 0;
        else begin
            if (wr_stb === 1'b1) begin
                if (q_addr.size() == 0) chk(0, "R3", "unexpected strobe", 1, 0);
                else begin
                    logic [7:0] ea; logic [55:0] ed; int el;
                    ea = q_addr.pop_front(); ed = q_data.pop_front(); el = q_len.pop_front();
                    chk(wr_addr === ea, "R1", "address", wr_addr, ea);
                    chk(wr_data === ed, "R1", "data", wr_data, ed);
                    chk(wr_nbytes === 4'(el), "R2", "data count", wr_nbytes, el);
                end
                model_busy = BUSY;
            end
            chk(ready === (model_busy == 0), "R4", "ready", ready, model_busy == 0);
            if (model_busy > 0) model_busy--;
            chk(miso_oe === ~csn, "R8", "miso enable", miso_oe, ~csn);
            chk(miso === 1'b0, "R8", "miso level", miso, 0);
        end
    end

    function automatic int exp_len(input logic [7:0] a);
        return (a[2:0] == 3'd7) ? 8 : int'(a[2:0]) + 2;
    endfunction

    task automatic send(input logic [7:0] b [9], input int nb, input int xbits, input bit drv_fall);
        bit armed;
        logic [7:0] eff [9];
        logic [55:0] ed;
        armed = (model_busy == 0);
        csn = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < nb * 8 + xbits; i++) begin
            bit bv;
            bv = b[i / 8][7 - (i % 8)];
            if (!drv_fall) begin
                mosi = bv;  repeat (H) @(negedge clk);
                sclk = 1'b1; repeat (H) @(negedge clk);
                sclk = 1'b0; mosi = ~bv;
            end else begin
                sclk = 1'b1; mosi = ~bv; repeat (H) @(negedge clk);
                sclk = 1'b0; mosi = bv;  repeat (H) @(negedge clk);
            end
        end
        repeat (6) @(negedge clk);
        for (int k = 0; k < 9; k++) eff[k] = (drv_fall == dut_fall) ? b[k] : ~b[k];
        if (armed && xbits == 0 && nb <= 8 && nb == exp_len(eff[0])) begin
            ed = '0;
            for (int k = 1; k < nb; k++) ed[(k-1)*8 +: 8] = eff[k];
            q_addr.push_back(eff[0]); q_data.push_back(ed); q_len.push_back(nb - 1);
        end
        csn = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic wait_idle(input string req);
        while (model_busy != 0) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(q_addr.size() == 0, req, "strobe missing", q_addr.size(), 0);
        chk(ready === 1'b1, req, "ready idle", ready, 1);
    endtask

    task automatic do_reset(input bit m);
        rst = 1'b1; mode_pin = m;
        repeat (4) @(negedge clk);
        rst = 1'b0; dut_fall = m;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R4", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic [7:0] f [9];
        do_reset(1'b1);
        // R9 reset state
        chk(ready === 1'b1, "R9", "reset ready", ready, 1);
        chk(wr_stb === 1'b0, "R9", "reset strobe", wr_stb, 0);
        chk(wr_addr === 8'h0, "R9", "reset addr", wr_addr, 0);
        chk(wr_data === 56'h0, "R9", "reset data", wr_data, 0);
        chk(wr_nbytes === 4'h0, "R9", "reset count", wr_nbytes, 0);

        // R1 R2 R4 falling-edge mode, several lengths
        f = '{8'h10, 8'hA5, 0, 0, 0, 0, 0, 0, 0};               send(f, 2, 0, 1'b1); wait_idle("R4");
        f = '{8'h23, 8'h01, 8'h80, 8'hFF, 8'h3C, 0, 0, 0, 0};   send(f, 5, 0, 1'b1); wait_idle("R2");
        f = '{8'h07, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 0};
        send(f, 8, 0, 1'b1); wait_idle("R1");
        f = '{8'h46, 8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h12, 8'h34, 8'h56, 0};
        send(f, 8, 0, 1'b1); wait_idle("R2");

        // R3 malformed frames
        f = '{8'h02, 8'h01, 8'h02, 8'h03, 8'h04, 0, 0, 0, 0};
        send(f, 3, 0, 1'b1); wait_idle("R3");
        send(f, 5, 0, 1'b1); wait_idle("R3");
        f = '{8'h10, 8'h5A, 8'hF0, 0, 0, 0, 0, 0, 0};
        send(f, 2, 3, 1'b1); wait_idle("R3");
        f = '{8'h07, 1, 2, 3, 4, 5, 6, 7, 8};
        send(f, 9, 0, 1'b1); wait_idle("R3");

        // R5 frame started during busy is dropped, the next one is taken
        f = '{8'h10, 8'h3C, 0, 0, 0, 0, 0, 0, 0};
        send(f, 2, 0, 1'b1);
        f = '{8'h11, 8'hC3, 8'h99, 0, 0, 0, 0, 0, 0};
        chk(model_busy > 5, "R5", "second frame starts while busy", model_busy, 6);
        send(f, 3, 0, 1'b1); wait_idle("R5");
        send(f, 3, 0, 1'b1); wait_idle("R5");

        // R6 rising-edge mode
        do_reset(1'b0);
        f = '{8'h21, 8'h81, 8'h42, 0, 0, 0, 0, 0, 0};         send(f, 3, 0, 1'b0); wait_idle("R6");
        // wrong-edge traffic reads inverted bytes and is rejected
        f = '{8'h10, 8'hAA, 0, 0, 0, 0, 0, 0, 0};             send(f, 2, 0, 1'b1); wait_idle("R6");
        // R7 mode pin changes after reset are ignored
        mode_pin = 1'b1;
        repeat (5) @(negedge clk);
        f = '{8'h34, 8'h0F, 8'hF0, 8'h55, 8'hAA, 8'h99, 0, 0, 0};
        send(f, 6, 0, 1'b0); wait_idle("R7");
        f = '{8'h10, 8'h77, 0, 0, 0, 0, 0, 0, 0};             send(f, 2, 0, 1'b1); wait_idle("R7");

        finish_run();
    end

endmodule